// File: doc/BRIEF.md
# Read-Delay Eye Scan Calibrator

This block centres the sampling point of a memory read data path. On a start request it steps a delay-line tap index through every position of the tap range. At each position it waits a short settle time and then issues a fixed number of test reads. It checks every returned burst, bit by bit, against a reference pattern. For each tap the block stores a single pass or fail bit, according to whether the bit errors collected over all repetitions of that tap stay within a programmable limit.

The block makes no decision while the sweep runs. Once every tap has been recorded, it reads the stored map back and finds the first and last passing taps. It then selects their truncated mean as the new tap. A map with no passing tap is rejected and reported. So is a passing window that runs off the end of the range and wraps back to tap 0. In both cases the previously selected tap is kept. A one-cycle done pulse marks the end of a calibration, and the chosen tap and the status code then hold until the next start.

Top module: `eyescan_cal`

## Requirements
- R1: After reset, `done`, `rd_req` and `busy` are 0, `cal_status` is 2'b00, and both `tap_set` and `result_tap` are 0.
- R2: A `start` pulse while idle raises `busy` and sweeps `tap_set` from 0 upward in steps of one to NUM_TAPS-1. A read is issued only while `busy` is high.
- R3: After each change of `tap_set`, at least SETTLE clock cycles pass before the next `rd_req`. `rd_req` is always a single-cycle pulse.
- R4: Exactly REPS reads are issued per tap, NUM_TAPS*REPS per calibration. A new read is issued only after all BEATS valid beats of the previous burst have been received.
- R5: Beat k of a burst (k counted from 0 in arrival order) is compared with `ref_burst[k*DQ_W +: DQ_W]`. A tap passes when the total number of mismatching bits over its REPS bursts is no greater than `err_limit`. A limit of 0 means a strict check.
- R6: Once all taps are recorded, if the passing taps form a window that does not wrap, `result_tap` becomes (first passing + last passing) >> 1 with truncation, and `cal_status` becomes 2'b01. A range in which every tap passes counts as such a window.
- R7: If no tap passes, `cal_status` becomes 2'b10 and `result_tap` keeps its previous value.
- R8: If tap 0 and tap NUM_TAPS-1 both pass and at least one failing tap lies between them, `cal_status` becomes 2'b11 and `result_tap` keeps its previous value.
- R9: `done` is high for exactly one cycle per calibration. In that cycle `busy` is low and `tap_set` equals `result_tap`. `result_tap`, `cal_status` and `tap_set` stay unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration; sampled only while idle |
| err_limit | input | ERR_W | Largest bit-error total per tap that still passes |
| ref_burst | input | BEATS*DQ_W | Expected burst, beat 0 in the least significant bits |
| rd_valid | input | 1 | A read-data beat is present on rd_data |
| rd_data | input | DQ_W | One beat of returned read data |
| rd_req | output | 1 | Single-cycle request for one test read burst |
| tap_set | output | TAP_W | Delay-line tap index driven to the delay primitive |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle pulse at the end of a calibration |
| result_tap | output | TAP_W | Selected tap from the last accepted calibration |
| cal_status | output | 2 | 00 none yet, 01 accepted, 10 no passing tap, 11 wrapped window |

## Verification
The hardest outcome to produce from the ports is the wrapped window. It needs passing taps at both ends of the range, a failing stretch between them, and a result that differs visibly from the retained tap. The bench models the memory by flipping one bit in every beat at taps that a per-run mask marks as failing. It runs a calibration that leaves a known good tap, then masks in end-straddling windows, which should leave that tap in place. The error limit boundary is covered the same way: every tap is corrupted by a known total of 32 bit errors, and the bench runs with limits just below and at that total.

// File: rtl/eyescan_pkg.sv
package eyescan_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE   = 2'b00,
    CAL_OK     = 2'b01,
    CAL_NOPASS = 2'b10,
    CAL_WRAP   = 2'b11
  } cal_status_e;

  typedef enum logic [2:0] {
    SW_IDLE,
    SW_SETTLE,
    SW_ISSUE,
    SW_WAIT,
    SW_TAPEND,
    SW_EVAL
  } sweep_state_e;

endpackage

// File: rtl/eyescan_sweep.sv
// Sweep sequencer: steps the tap, waits for settle, issues reads,
// counts bursts per tap and hands off to the window evaluator.
module eyescan_sweep
  import eyescan_pkg::*;
#(
  parameter int NUM_TAPS = 512,
  parameter int REPS     = 1024,
  parameter int SETTLE   = 4,
  parameter int TAP_W    = 9,
  parameter int REP_W    = 10,
  parameter int SET_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             burst_done,
  input  logic             eval_done,
  input  logic [TAP_W-1:0] load_tap,
  output logic [TAP_W-1:0] tap_q,
  output logic             rd_req,
  output logic             busy,
  output logic             tap_end,
  output logic             eval_start
);

  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);
  localparam logic [REP_W-1:0] LAST_REP = REP_W'(REPS - 1);
  localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETTLE - 1);

  sweep_state_e        state_q;
  logic [REP_W-1:0]    rep_q;
  logic [SET_W-1:0]    set_q;

  assign rd_req     = (state_q == SW_ISSUE);
  assign busy       = (state_q != SW_IDLE);
  assign tap_end    = (state_q == SW_TAPEND);
  assign eval_start = tap_end && (tap_q == LAST_TAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SW_IDLE;
      tap_q   <= '0;
      rep_q   <= '0;
      set_q   <= '0;
    end else begin
      unique case (state_q)
        SW_IDLE: begin
          if (start) begin
            tap_q   <= '0;
            rep_q   <= '0;
            set_q   <= '0;
            state_q <= SW_SETTLE;
          end
        end
        SW_SETTLE: begin
          if (set_q == LAST_SET) begin
            state_q <= SW_ISSUE;
          end else begin
            set_q <= set_q + 1'b1;
          end
        end
        SW_ISSUE: state_q <= SW_WAIT;
        SW_WAIT: begin
          if (burst_done) begin
            if (rep_q == LAST_REP) begin
              rep_q   <= '0;
              state_q <= SW_TAPEND;
            end else begin
              rep_q   <= rep_q + 1'b1;
              state_q <= SW_ISSUE;
            end
          end
        end
        SW_TAPEND: begin
          if (tap_q == LAST_TAP) begin
            state_q <= SW_EVAL;
          end else begin
            tap_q   <= tap_q + 1'b1;
            set_q   <= '0;
            state_q <= SW_SETTLE;
          end
        end
        SW_EVAL: begin
          if (eval_done) begin
            tap_q   <= load_tap;
            state_q <= SW_IDLE;
          end
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eyescan_beat_check.sv
// Compares each returned beat with its slice of the reference burst and
// accumulates a saturating bit-error total for the current tap.
module eyescan_beat_check #(
  parameter int BEATS  = 8,
  parameter int DQ_W   = 8,
  parameter int ERR_W  = 16,
  parameter int BEAT_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  rd_valid,
  input  logic [DQ_W-1:0]       rd_data,
  input  logic [BEATS*DQ_W-1:0] ref_burst,
  output logic [ERR_W-1:0]      err_cnt,
  output logic                  burst_done
);

  localparam int PC_W = $clog2(DQ_W + 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic [BEAT_W-1:0] beat_q;
  logic [DQ_W-1:0]   exp_beat;
  logic [DQ_W-1:0]   mism;
  logic [PC_W-1:0]   pc;
  logic [ERR_W:0]    sum;

  assign exp_beat   = ref_burst[beat_q*DQ_W +: DQ_W];
  assign mism       = rd_data ^ exp_beat;
  assign burst_done = rd_valid && (beat_q == LAST_BEAT);

  always_comb begin
    pc = '0;
    for (int i = 0; i < DQ_W; i++) begin
      pc = pc + PC_W'(mism[i]);
    end
  end

  assign sum = {1'b0, err_cnt} + {{(ERR_W + 1 - PC_W){1'b0}}, pc};

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q  <= '0;
      err_cnt <= '0;
    end else begin
      if (rd_valid) begin
        beat_q <= burst_done ? '0 : beat_q + 1'b1;
      end
      if (clr) begin
        err_cnt <= '0;
      end else if (rd_valid) begin
        err_cnt <= sum[ERR_W] ? {ERR_W{1'b1}} : sum[ERR_W-1:0];
      end
    end
  end

endmodule

// File: rtl/eyescan_window.sv
// Pass bitmap (one bit per tap, block-RAM style) plus a sequential
// post-sweep scan that finds the first and last passing taps and a wrap.
module eyescan_window #(
  parameter int NUM_TAPS = 512,
  parameter int TAP_W    = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [TAP_W-1:0] waddr,
  input  logic             wbit,
  input  logic             eval_start,
  output logic             eval_done,
  output logic             found,
  output logic             wrap,
  output logic [TAP_W-1:0] first_tap,
  output logic [TAP_W-1:0] last_tap
);

  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

  logic             pass_mem [NUM_TAPS];
  logic [TAP_W-1:0] raddr_q;
  logic [TAP_W-1:0] ridx_q;
  logic             rbit_q;
  logic             rv_q;
  logic             run_q;
  logic             any_q;
  logic             hole_q;
  logic             bit0_q;

  always_ff @(posedge clk) begin
    if (we) begin
      pass_mem[waddr] <= wbit;
    end
    rbit_q <= pass_mem[raddr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      rv_q      <= 1'b0;
      raddr_q   <= '0;
      ridx_q    <= '0;
      any_q     <= 1'b0;
      hole_q    <= 1'b0;
      bit0_q    <= 1'b0;
      eval_done <= 1'b0;
      found     <= 1'b0;
      wrap      <= 1'b0;
      first_tap <= '0;
      last_tap  <= '0;
    end else begin
      eval_done <= 1'b0;
      if (eval_start) begin
        run_q   <= 1'b1;
        rv_q    <= 1'b0;
        raddr_q <= '0;
        any_q   <= 1'b0;
        hole_q  <= 1'b0;
        bit0_q  <= 1'b0;
      end else begin
        rv_q   <= run_q;
        ridx_q <= raddr_q;
        if (run_q) begin
          if (raddr_q == LAST_TAP) begin
            run_q <= 1'b0;
          end else begin
            raddr_q <= raddr_q + 1'b1;
          end
        end
        if (rv_q) begin
          if (rbit_q) begin
            if (!any_q) begin
              first_tap <= ridx_q;
            end
            last_tap <= ridx_q;
            any_q    <= 1'b1;
          end else if (any_q) begin
            hole_q <= 1'b1;
          end
          if (ridx_q == '0) begin
            bit0_q <= rbit_q;
          end
          if (ridx_q == LAST_TAP) begin
            eval_done <= 1'b1;
            found     <= any_q || rbit_q;
            wrap      <= bit0_q && rbit_q && hole_q;
          end
        end
      end
    end
  end

endmodule

// File: rtl/eyescan_cal.sv
// Top level: read-delay eye scan calibrator.
module eyescan_cal
  import eyescan_pkg::*;
#(
  parameter int NUM_TAPS = 512,
  parameter int REPS     = 1024,
  parameter int BEATS    = 8,
  parameter int DQ_W     = 8,
  parameter int SETTLE   = 4,
  parameter int ERR_W    = 16,
  localparam int TAP_W   = $clog2(NUM_TAPS),
  localparam int REP_W   = $clog2(REPS),
  localparam int BEAT_W  = $clog2(BEATS),
  localparam int SET_W   = $clog2(SETTLE + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [ERR_W-1:0]      err_limit,
  input  logic [BEATS*DQ_W-1:0] ref_burst,
  input  logic                  rd_valid,
  input  logic [DQ_W-1:0]       rd_data,
  output logic                  rd_req,
  output logic [TAP_W-1:0]      tap_set,
  output logic                  busy,
  output logic                  done,
  output logic [TAP_W-1:0]      result_tap,
  output logic [1:0]            cal_status
);

  logic             burst_done;
  logic             eval_done;
  logic             eval_start;
  logic             tap_end;
  logic             found;
  logic             wrap;
  logic [ERR_W-1:0] err_cnt;
  logic [TAP_W-1:0] first_tap;
  logic [TAP_W-1:0] last_tap;
  logic [TAP_W:0]   span;
  logic [TAP_W-1:0] mid_tap;
  logic             accept;
  logic [TAP_W-1:0] load_tap;
  cal_status_e      status_q;

  assign span     = {1'b0, first_tap} + {1'b0, last_tap};
  assign mid_tap  = span[TAP_W:1];
  assign accept   = found && !wrap;
  assign load_tap = accept ? mid_tap : result_tap;

  eyescan_sweep #(
    .NUM_TAPS(NUM_TAPS), .REPS(REPS), .SETTLE(SETTLE),
    .TAP_W(TAP_W), .REP_W(REP_W), .SET_W(SET_W)
  ) u_sweep (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .burst_done (burst_done),
    .eval_done  (eval_done),
    .load_tap   (load_tap),
    .tap_q      (tap_set),
    .rd_req     (rd_req),
    .busy       (busy),
    .tap_end    (tap_end),
    .eval_start (eval_start)
  );

  eyescan_beat_check #(
    .BEATS(BEATS), .DQ_W(DQ_W), .ERR_W(ERR_W), .BEAT_W(BEAT_W)
  ) u_check (
    .clk        (clk),
    .rst        (rst),
    .clr        (tap_end),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .ref_burst  (ref_burst),
    .err_cnt    (err_cnt),
    .burst_done (burst_done)
  );

  eyescan_window #(
    .NUM_TAPS(NUM_TAPS), .TAP_W(TAP_W)
  ) u_window (
    .clk        (clk),
    .rst        (rst),
    .we         (tap_end),
    .waddr      (tap_set),
    .wbit       (err_cnt <= err_limit),
    .eval_start (eval_start),
    .eval_done  (eval_done),
    .found      (found),
    .wrap       (wrap),
    .first_tap  (first_tap),
    .last_tap   (last_tap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      result_tap <= '0;
      status_q   <= CAL_IDLE;
    end else begin
      done <= eval_done;
      if (eval_done) begin
        if (!found) begin
          status_q <= CAL_NOPASS;
        end else if (wrap) begin
          status_q <= CAL_WRAP;
        end else begin
          status_q   <= CAL_OK;
          result_tap <= mid_tap;
        end
      end
    end
  end

  assign cal_status = status_q;

endmodule

// File: rtl/eyescan_cal_chk.sv
module eyescan_cal_chk #(
  parameter int TAP_W  = 9,
  parameter int SETTLE = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             rd_req,
  input logic [TAP_W-1:0] tap_set,
  input logic [TAP_W-1:0] result_tap,
  input logic [1:0]       cal_status
);

  localparam int CW = $clog2(SETTLE + 2) + 1;

  logic [TAP_W-1:0] prev_tap;
  logic [CW-1:0]    since_q;
  logic [CW-1:0]    since_eff;

  assign since_eff = (tap_set != prev_tap) ? '0 : since_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_tap <= '0;
      since_q  <= '1;
    end else begin
      prev_tap <= tap_set;
      since_q  <= (since_eff == '1) ? since_eff : since_eff + 1'b1;
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r3_req_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  a_r2_req_busy: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy);

  a_r3_settle: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (since_eff >= CW'(SETTLE)));

  a_r2_tap_step: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (tap_set != $past(tap_set)))
      |-> (tap_set == $past(tap_set) + 1'b1));

  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && tap_set == result_tap && cal_status != 2'b00));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(cal_status) && $stable(result_tap)
                           && $stable(tap_set)));

  a_r7_nopass_keep: assert property (@(posedge clk) disable iff (rst)
    (done && cal_status == 2'b10) |-> $stable(result_tap));

  a_r8_wrap_keep: assert property (@(posedge clk) disable iff (rst)
    (done && cal_status == 2'b11) |-> $stable(result_tap));

endmodule

bind eyescan_cal eyescan_cal_chk #(
  .TAP_W(TAP_W), .SETTLE(SETTLE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .rd_req     (rd_req),
  .tap_set    (tap_set),
  .result_tap (result_tap),
  .cal_status (cal_status)
);

// File: tb/eyescan_cal_bench.sv
`timescale 1ns/1ps
module eyescan_cal_bench;

  localparam int NUM_TAPS = 16;
  localparam int REPS     = 4;
  localparam int BEATS    = 8;
  localparam int DQ_W     = 8;
  localparam int SETTLE   = 3;
  localparam int ERR_W    = 16;
  localparam int TAP_W    = 4;
  localparam logic [63:0] REF = 64'h0123_4567_89AB_CDEF;

  // {pass mask[21:6], expected status[5:4], expected tap[3:0]}
  localparam int NVEC = 9;
  localparam logic [21:0] VEC [NVEC] = '{
    {16'h0FF0, 2'b01, 4'd7},   // R6 centred window
    {16'h0038, 2'b01, 4'd4},   // R6 narrow window
    {16'h0000, 2'b10, 4'd4},   // R7 nothing passes, keep 4
    {16'hC003, 2'b11, 4'd4},   // R8 wrap, keep 4
    {16'hFFFF, 2'b01, 4'd7},   // R8 all pass is not a wrap, R6
    {16'h0001, 2'b01, 4'd0},   // R6 only first tap
    {16'h8000, 2'b01, 4'd15},  // R6 only last tap
    {16'h0006, 2'b01, 4'd1},   // R6 truncation (1+2)>>1
    {16'h8001, 2'b11, 4'd1}    // R8 minimal wrap, keep 1
  };

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  start = 1'b0;
  logic [ERR_W-1:0]      err_limit = '0;
  logic [BEATS*DQ_W-1:0] ref_burst = REF;
  logic                  rd_valid = 1'b0;
  logic [DQ_W-1:0]       rd_data = '0;
  logic                  rd_req;
  logic [TAP_W-1:0]      tap_set;
  logic                  busy;
  logic                  done;
  logic [TAP_W-1:0]      result_tap;
  logic [1:0]            cal_status;

  int compared   = 0;
  int mismatched = 0;
  int req_cnt    = 0;
  int since      = 1000;
  logic [TAP_W-1:0] prev_tap = '0;
  logic [15:0] pass_mask = '0;
  bit aborted = 1'b0;

  always #4 clk = ~clk;

  eyescan_cal #(
    .NUM_TAPS(NUM_TAPS), .REPS(REPS), .BEATS(BEATS),
    .DQ_W(DQ_W), .SETTLE(SETTLE), .ERR_W(ERR_W)
  ) u_eyescan_cal (
    .clk(clk), .rst(rst), .start(start), .err_limit(err_limit),
    .ref_burst(ref_burst), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_req(rd_req), .tap_set(tap_set), .busy(busy), .done(done),
    .result_tap(result_tap), .cal_status(cal_status)
  );

  task automatic chk(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Memory model: one latency cycle, then BEATS beats; failing taps get
  // bit 0 of every beat flipped (32 bit errors per tap).
  initial begin
    logic bad;
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (rd_req) begin
        bad = !pass_mask[tap_set];
        for (int b = 0; b < BEATS; b++) begin
          @(negedge clk);
          if (rd_req) chk("R4 request during burst", 1, 0);
          rd_valid = 1'b1;
          rd_data  = REF[b*DQ_W +: DQ_W] ^ {{(DQ_W-1){1'b0}}, bad};
        end
      end
    end
  end

  // Read monitor: tap order (R2) and settle gap (R3).
  always @(negedge clk) begin
    if (!rst) begin
      if (tap_set != prev_tap) since = 0;
      else if (since < 1000) since = since + 1;
      prev_tap = tap_set;
      if (rd_req) begin
        chk("R2 tap at read", int'(tap_set), req_cnt / REPS);
        if (since < SETTLE) chk("R3 settle gap", since, SETTLE);
        req_cnt = req_cnt + 1;
      end
    end
  end

  task automatic run_cal(input logic [15:0] mask, input int limit,
                         input int exp_stat, input int exp_tap,
                         input string tag);
    int guard;
    pass_mask = mask;
    err_limit = ERR_W'(limit);
    req_cnt   = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R2 busy after start"}, int'(busy), 1);
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    if (!done) begin
      chk({tag, " watchdog"}, 0, 1);
      aborted = 1'b1;
    end else begin
      chk({tag, " status"}, int'(cal_status), exp_stat);
      chk({tag, " result tap"}, int'(result_tap), exp_tap);
      chk({tag, " R9 tap_set at done"}, int'(tap_set), exp_tap);
      chk({tag, " R9 busy low at done"}, int'(busy), 0);
      chk({tag, " R4 read count"}, req_cnt, NUM_TAPS * REPS);
      @(negedge clk);
      chk({tag, " R9 done one cycle"}, int'(done), 0);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done", int'(done), 0);
    chk("R1 rd_req", int'(rd_req), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 status", int'(cal_status), 0);
    chk("R1 tap_set", int'(tap_set), 0);
    chk("R1 result", int'(result_tap), 0);

    for (int v = 0; v < NVEC; v++) begin
      if (!aborted)
        run_cal(VEC[v][21:6], 0, int'(VEC[v][5:4]), int'(VEC[v][3:0]),
                $sformatf("vec%0d R6/R7/R8", v));
    end

    // R5 error limit boundary: every tap carries 32 bit errors.
    if (!aborted) run_cal(16'h0000, 31, 2, 1, "R5 limit below");
    if (!aborted) run_cal(16'h0000, 32, 1, 7, "R5 limit equal");

    // R9 hold while idle.
    if (!aborted) begin
      repeat (20) @(negedge clk);
      chk("R9 status hold", int'(cal_status), 1);
      chk("R9 result hold", int'(result_tap), 7);
      chk("R9 tap hold", int'(tap_set), 7);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             compared, mismatched);
    $finish;
  end

endmodule